// File: doc/BRIEF.md
# Packed SIMD Add and Logic Unit

A 64-bit packed integer unit that takes two operands and an operation byte and returns a registered result one clock later. Additions split the operand into independent lanes of 8, 16 or 32 bits. No carry crosses a lane boundary. Each lane either wraps, clamps to its signed range, or clamps to its unsigned range.

Besides addition, the unit offers a plain 64-bit AND and an AND in which only the destination operand is inverted. A new operation can be accepted on every clock. An operation byte that is not recognised produces no valid result and leaves the last result in place.

The reset input is asserted asynchronously. Its release is taken through a two-stage synchronizer, so the unit accepts work from the third rising edge after the reset input goes high.

Top module: `psimd_alu`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `out_data` is 0.
- R2: Operation bytes 0xFC, 0xFD and 0xFE add byte, word and dword lanes with wrap-around. Each lane result is the lane sum modulo 2^lane width, and no carry passes into the next lane.
- R3: Operation bytes 0xEC (byte) and 0xED (word) add the lanes as two's-complement values. A sum above the lane maximum gives 0x7F / 0x7FFF, and a sum below the lane minimum gives 0x80 / 0x8000.
- R4: Operation bytes 0xDC (byte) and 0xDD (word) add the lanes as unsigned values. A sum above the all-ones lane value gives the all-ones value.
- R5: Operation byte 0xDB returns the bitwise AND of `in_dst` and `in_src`.
- R6: Operation byte 0xDF returns the bitwise AND of the inverted `in_dst` with `in_src`.
- R7: An accepted operation (`in_valid` high with a recognised byte) shows its result with `out_valid` high on the next clock. Back-to-back operations each produce a result on consecutive clocks.
- R8: When `in_valid` is low or the operation byte is unrecognised, `out_valid` is low on the next clock and `out_data` keeps its previous value. Unrecognised bytes include 0xDE and 0xEE, because no saturating dword addition exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released through a synchronizer |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 8 | Operation byte |
| in_dst | input | 64 | Destination operand |
| in_src | input | 64 | Source operand |
| out_valid | output | 1 | Result valid, one clock after acceptance |
| out_data | output | 64 | Registered result |

## Verification
Two effects can meet in one cycle: one lane overflows and clamps while the lane next to it sits at a boundary value that a leaked carry would change. The bench provokes this with operands that are all ones, with alternating 0x7F/0x80 lane patterns, and with the dword carry edge. It then compares every lane against a reference model in the bench. A second collision is a rejected operation byte arriving directly after an accepted one. The bench judges it by checking that `out_valid` drops while `out_data` still holds the earlier result.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  typedef enum logic [1:0] {OPK_NONE, OPK_ADD, OPK_AND, OPK_ANDN} op_kind_t;
  typedef enum logic [1:0] {LW_B, LW_W, LW_D} lane_w_t;
  typedef enum logic [1:0] {SM_WRAP, SM_SGN, SM_UNS} sat_mode_t;
endpackage

// File: rtl/psimd_decode.sv
module psimd_decode
  import psimd_pkg::*;
(
  input  logic [7:0] op,
  output logic       known,
  output op_kind_t   kind,
  output lane_w_t    lw,
  output sat_mode_t  sm
);
  always_comb begin
    known = 1'b1;
    kind  = OPK_ADD;
    lw    = LW_B;
    sm    = SM_WRAP;
    case (op)
      8'hFC: begin lw = LW_B; sm = SM_WRAP; end
      8'hFD: begin lw = LW_W; sm = SM_WRAP; end
      8'hFE: begin lw = LW_D; sm = SM_WRAP; end
      8'hEC: begin lw = LW_B; sm = SM_SGN;  end
      8'hED: begin lw = LW_W; sm = SM_SGN;  end
      8'hDC: begin lw = LW_B; sm = SM_UNS;  end
      8'hDD: begin lw = LW_W; sm = SM_UNS;  end
      8'hDB: kind = OPK_AND;
      8'hDF: kind = OPK_ANDN;
      default: begin
        known = 1'b0;
        kind  = OPK_NONE;
      end
    endcase
  end
endmodule

// File: rtl/psimd_lane.sv
module psimd_lane
  import psimd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  sat_mode_t    sm,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] UMAX = {W{1'b1}};

  logic [W:0]   sum;
  logic [W-1:0] wrap;
  logic         s_ovf;

  always_comb begin
    sum   = {1'b0, a} + {1'b0, b};
    wrap  = sum[W-1:0];
    s_ovf = (a[W-1] == b[W-1]) && (wrap[W-1] != a[W-1]);
    case (sm)
      SM_SGN:  y = s_ovf ? (a[W-1] ? SMIN : SMAX) : wrap;
      SM_UNS:  y = sum[W] ? UMAX : wrap;
      default: y = wrap;
    endcase
  end
endmodule

// File: rtl/psimd_alu.sv
module psimd_alu
  import psimd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_op,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int NB = DATA_W / 8;
  localparam int NW = DATA_W / 16;
  localparam int ND = DATA_W / 32;

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic      known;
  op_kind_t  kind;
  lane_w_t   lw;
  sat_mode_t sm;

  psimd_decode u_dec (
    .op(in_op), .known(known), .kind(kind), .lw(lw), .sm(sm)
  );

  logic [DATA_W-1:0] sum_b, sum_w, sum_d;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    psimd_lane #(.W(8)) u_l (
      .a(in_dst[i*8 +: 8]), .b(in_src[i*8 +: 8]), .sm(sm), .y(sum_b[i*8 +: 8])
    );
  end
  for (genvar i = 0; i < NW; i++) begin : g_word
    psimd_lane #(.W(16)) u_l (
      .a(in_dst[i*16 +: 16]), .b(in_src[i*16 +: 16]), .sm(sm), .y(sum_w[i*16 +: 16])
    );
  end
  for (genvar i = 0; i < ND; i++) begin : g_dword
    psimd_lane #(.W(32)) u_l (
      .a(in_dst[i*32 +: 32]), .b(in_src[i*32 +: 32]), .sm(SM_WRAP), .y(sum_d[i*32 +: 32])
    );
  end

  logic [DATA_W-1:0] res_d;
  logic              fire;
  logic              vld_d;

  always_comb begin
    case (kind)
      OPK_ADD: begin
        case (lw)
          LW_W:    res_d = sum_w;
          LW_D:    res_d = sum_d;
          default: res_d = sum_b;
        endcase
      end
      OPK_AND:  res_d = in_dst & in_src;
      OPK_ANDN: res_d = ~in_dst & in_src;
      default:  res_d = '0;
    endcase
    fire  = in_valid && known;
    vld_d = fire;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_valid <= 1'b0;
    else            out_valid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  out_data <= '0;
    else if (fire)   out_data <= res_d;
  end
endmodule

// File: rtl/psimd_alu_chk.sv
module psimd_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_int_n,
  input logic              in_valid,
  input logic [7:0]        in_op,
  input logic [DATA_W-1:0] in_dst,
  input logic [DATA_W-1:0] in_src,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  logic ok_op;
  assign ok_op = in_op inside {8'hFC, 8'hFD, 8'hFE, 8'hEC, 8'hED,
                               8'hDC, 8'hDD, 8'hDB, 8'hDF};

  always_comb begin
    if (!rst_n) p_reset_r1: assert (!out_valid && out_data == '0);
  end

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && ok_op) |=> out_valid);

  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(in_valid && ok_op) |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(in_valid && ok_op) |=> $stable(out_data));

  p_and_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_op == 8'hDB) |=> out_data == ($past(in_dst) & $past(in_src)));

  p_andn_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_op == 8'hDF) |=> out_data == (~$past(in_dst) & $past(in_src)));

  p_dword_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_op == 8'hFE) |=>
      out_data[31:0] == ($past(in_dst[31:0]) + $past(in_src[31:0])));
endmodule

bind psimd_alu psimd_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n), .in_valid(in_valid),
  .in_op(in_op), .in_dst(in_dst), .in_src(in_src),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_psimd_alu.sv
module sim_psimd_alu;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_op;
  logic [63:0] in_dst, in_src;
  logic        out_valid;
  logic [63:0] out_data;

  int nchk = 0;
  int nbad = 0;
  logic [63:0] exp_hold;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  psimd_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] lane_add(input logic [63:0] d, input logic [63:0] s,
                                           input int w, input int mode);
    logic [63:0] r = '0;
    longint mask = (longint'(1) << w) - 1;
    for (int i = 0; i < 64 / w; i++) begin
      longint a = longint'((d >> (i * w))) & mask;
      longint b = longint'((s >> (i * w))) & mask;
      longint t;
      if (mode == 1) begin
        longint half = longint'(1) << (w - 1);
        if (a >= half) a = a - (longint'(1) << w);
        if (b >= half) b = b - (longint'(1) << w);
        t = a + b;
        if (t > half - 1) t = half - 1;
        if (t < -half)    t = -half;
      end else begin
        t = a + b;
        if (mode == 2 && t > mask) t = mask;
      end
      r = r | ((64'(t) & 64'(mask)) << (i * w));
    end
    return r;
  endfunction

  function automatic bit ref_op(input logic [7:0] op, input logic [63:0] d,
                                input logic [63:0] s, output logic [63:0] r);
    ref_op = 1'b1;
    r = '0;
    case (op)
      8'hFC: r = lane_add(d, s, 8, 0);
      8'hFD: r = lane_add(d, s, 16, 0);
      8'hFE: r = lane_add(d, s, 32, 0);
      8'hEC: r = lane_add(d, s, 8, 1);
      8'hED: r = lane_add(d, s, 16, 1);
      8'hDC: r = lane_add(d, s, 8, 2);
      8'hDD: r = lane_add(d, s, 16, 2);
      8'hDB: r = d & s;
      8'hDF: r = ~d & s;
      default: ref_op = 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] op, input bit v);
    if (!v) return "R8";
    case (op)
      8'hFC, 8'hFD, 8'hFE: return "R2";
      8'hEC, 8'hED:        return "R3";
      8'hDC, 8'hDD:        return "R4";
      8'hDB:               return "R5";
      8'hDF:               return "R6";
      default:             return "R8";
    endcase
  endfunction

  task automatic do_op(input logic v, input logic [7:0] op,
                       input logic [63:0] d, input logic [63:0] s);
    logic [63:0] r;
    bit acc;
    in_valid = v; in_op = op; in_dst = d; in_src = s;
    acc = ref_op(op, d, s, r) && v;
    if (acc) exp_hold = r;
    @(negedge clk);
    nchk++;
    if (out_valid !== acc || out_data !== exp_hold) begin
      nbad++;
      $display("FAIL %s (R7 timing) op=%02h: got v=%b d=%016h exp v=%b d=%016h",
               req_of(op, acc), op, out_valid, out_data, acc, exp_hold);
    end
  endtask

  initial begin
    if (CLK_P * 200000 > 0) begin
      #(CLK_P * 150000);
      if (!done) begin
        nbad++;
        $display("FAIL watchdog: got hung exp finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] ops[14] = '{8'hFC, 8'hFD, 8'hFE, 8'hEC, 8'hED, 8'hDC, 8'hDD,
                            8'hDB, 8'hDF, 8'hDE, 8'hEE, 8'hFF, 8'h00, 8'hFC};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_dst = '0; in_src = '0;
    exp_hold = '0;
    repeat (3) @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0 || out_data !== 64'h0) begin
      nbad++;
      $display("FAIL R1 reset: got v=%b d=%016h exp v=0 d=0", out_valid, out_data);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 lane isolation, wrap at every width
    do_op(1, 8'hFC, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    do_op(1, 8'hFD, 64'h00FF_FFFF_7FFF_8000, 64'h0001_0001_0001_8000);
    do_op(1, 8'hFE, 64'h0000_0005_FFFF_FFFF, 64'h0000_0000_0000_0001);
    // R3 signed clamps, alternating lanes
    do_op(1, 8'hEC, 64'h7F80_7F80_7F80_0102, 64'h0180_7F80_FFFF_0304);
    do_op(1, 8'hED, 64'h7FFF_8000_7FFF_1234, 64'h0001_FFFF_8000_0001);
    // R4 unsigned clamps
    do_op(1, 8'hDC, 64'hFF80_FE01_0000_7F7F, 64'h0180_0101_0000_8081);
    do_op(1, 8'hDD, 64'hFFFF_8000_0001_1234, 64'h0001_8000_FFFE_0001);
    // R5, R6
    do_op(1, 8'hDB, 64'hF0F0_1234_FFFF_0000, 64'hFF00_FFFF_5A5A_FFFF);
    do_op(1, 8'hDF, 64'hF0F0_1234_FFFF_0000, 64'hFF00_FFFF_5A5A_FFFF);
    // R8: rejected bytes and idle cycles right after an accepted op
    do_op(1, 8'hDE, 64'h1, 64'h2);
    do_op(1, 8'hEE, 64'h3, 64'h4);
    do_op(0, 8'hFC, 64'h5, 64'h6);
    // R7 back-to-back random stream
    for (int k = 0; k < 600; k++) begin
      logic [7:0] op = ops[$urandom_range(0, 13)];
      logic v = ($urandom_range(0, 7) != 0);
      logic [63:0] d = {$urandom, $urandom};
      logic [63:0] s = {$urandom, $urandom};
      if ((k % 5) == 0) s = ~d;
      if ((k % 7) == 0) begin d = 64'h7F7F_7F7F_7F7F_7F7F; end
      do_op(v, op, d, s);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule